// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the software-facing register file of a descriptor-based DMA engine with a parameterised number of channels. A 32-bit word bus reaches each channel through its own 8 KiB window. In each window the block holds the current descriptor pointer, the buffer position, the group and context pointers, the configuration, command and stream-command words, and the interrupt mask and raw pending bits.

From these registers it keeps a one-hot run state and an end-of-list flag per channel, and drives one level interrupt per channel. It sends single-cycle request pulses to the datapath: descriptor load, context load, start and continue. Descriptor fetch and data movement sit in the datapath. The datapath reports back through a few inputs: whether a client is attached, the end-of-list bit of the current descriptor, an end-of-list event, raw interrupt events and the stream command source.

Every bus request gets a registered response in the following cycle. Register writes, state changes and request pulses all take effect at the same clock edge as that response.

Top module: `dma_chan_ctrl`

## Requirements
- R1: The channel is selected by address bits 13 and up, and the register by address bits [7:2]. The byte offsets are:

  | Register | Offset |
  |---|---|
  | descriptor pointer | 0x00 |
  | saved descriptor | 0x58 |
  | saved buffer | 0x5C |
  | group | 0x60 |
  | group-down | 0x7C |
  | command | 0x80 |
  | configuration | 0x84 |
  | status | 0x88 |
  | mask | 0x8C |
  | acknowledge | 0x90 |
  | raw pending | 0x94 |
  | masked pending | 0x98 |
  | stream command | 0x9C |

  A write to one channel leaves every other channel unchanged.
- R2: After reset every register reads 0 except status, which reads 0x101. All irq and request pulse outputs are low.
- R3: An access with req_size other than 2 (0 = byte, 1 = half, 2 = word) gets resp_err=1 and resp_rdata=0, and changes no register. Every request gets resp_valid exactly one cycle later.
- R4: Offsets not listed in R1 read 0, and writes to them have no effect. Status is read-only.
- R5: A configuration write stores the word. Bit 0 is enable and bit 1 is stop. If bit 1 is set, the state becomes STOPPED. If bit 0 is clear, the state becomes RST, and this wins over bit 1. Otherwise the state is unchanged.
- R6: Status reads the run state one-hot in bits [2:0] (RST=1, STOPPED=2, RUNNING=4), the end-of-list flag in bit 5 and the stream command source in bits [8+SRC_W-1:8]. Exactly one state bit is ever set.
- R7: A stream command write keeps bits [9:0] and reads them back. If bit 6 or bit 8 is set, it pulses load_d_o. If bit 5 is also set, it attempts a start. If bit 9 is set, it pulses load_c_o.
- R8: A start attempt takes effect only while client_present is high for that channel. It then clears the end-of-list flag, sets the state to RUNNING and pulses start_o.
- R9: A command write pulses cont_o only if all of these hold for that channel: configuration bit 0 set, bit 1 clear, client present, state RUNNING, and desc_eol high. Otherwise it produces no pulse.
- R10: Raw pending bits are set by intr_set. Writing acknowledge clears the raw bits that are set in the written value. Acknowledge always reads 0. A bit set by intr_set in the same cycle as its acknowledge stays set.
- R11: Masked pending reads raw AND mask, and irq is high exactly when the masked value is non-zero.
- R12: An eol_hit pulse sets the end-of-list flag. A src_we pulse loads src_val into the stream command source, which resets to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response, one cycle after request |
| resp_err | output | 1 | Access size error |
| resp_rdata | output | 32 | Read data |
| client_present | input | NUM_CH | Client attached, per channel |
| desc_eol | input | NUM_CH | End-of-list bit of current descriptor |
| eol_hit | input | NUM_CH | Datapath reached end of list (pulse) |
| intr_set | input | NUM_CH*INTR_W | Raw interrupt set events |
| src_we | input | NUM_CH | Load stream command source |
| src_val | input | NUM_CH*SRC_W | New stream command source |
| irq | output | NUM_CH | Interrupt line per channel |
| load_d_o | output | NUM_CH | Descriptor load request pulse |
| load_c_o | output | NUM_CH | Context load request pulse |
| start_o | output | NUM_CH | Channel start pulse |
| cont_o | output | NUM_CH | Continue request pulse |

## Verification
The stream command decoder is driven with several codes:
- descriptor load with burst, which separates start from plain load;
- load alone;
- context load alone;
- burst alone, which must produce nothing.

The descriptor load with burst code is repeated with the client absent and then present, which shows the start gate. Configuration writes step through enable only, enable with stop, and disabled with stop, which shows the order of priority among the state updates.

The continue command is tried with every one of its conditions met, then with end-of-list low, then with the channel stopped. Interrupt tests combine mask and acknowledge patterns, including a set and an acknowledge in the same cycle, which shows whether events are lost.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  typedef enum logic [2:0] {
    ST_RST  = 3'b001,
    ST_STOP = 3'b010,
    ST_RUN  = 3'b100
  } run_state_e;

  // register word indices (byte offset / 4)
  localparam logic [5:0] IX_DPTR  = 6'h00;
  localparam logic [5:0] IX_SDESC = 6'h16;
  localparam logic [5:0] IX_SBUF  = 6'h17;
  localparam logic [5:0] IX_GRP   = 6'h18;
  localparam logic [5:0] IX_GDN   = 6'h1F;
  localparam logic [5:0] IX_CMD   = 6'h20;
  localparam logic [5:0] IX_CFG   = 6'h21;
  localparam logic [5:0] IX_STAT  = 6'h22;
  localparam logic [5:0] IX_MASK  = 6'h23;
  localparam logic [5:0] IX_ACK   = 6'h24;
  localparam logic [5:0] IX_RAW   = 6'h25;
  localparam logic [5:0] IX_MSKD  = 6'h26;
  localparam logic [5:0] IX_SCMD  = 6'h27;

  localparam logic [1:0] SIZE_WORD = 2'd2;
  localparam logic [9:0] SC_LOADD  = 10'h140;
  localparam int         SC_BURST  = 5;
  localparam int         SC_LOADC  = 9;
  localparam int         WIN_LSB   = 13;
endpackage

// File: rtl/dma_bus_decode.sv
module dma_bus_decode #(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1,
  parameter int ADDR_W = 14
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              acc_ok,
  output logic              acc_err,
  output logic              wr_go,
  output logic [CH_W-1:0]   ch_sel,
  output logic [5:0]        reg_idx
);
  import dma_regs_pkg::*;

  logic in_range;
  logic unused_addr;

  assign unused_addr = ^{req_addr[WIN_LSB-1:8], req_addr[1:0]};
  assign ch_sel      = req_addr[ADDR_W-1:WIN_LSB];
  assign reg_idx     = req_addr[7:2];
  assign in_range    = 32'(ch_sel) < NUM_CH;
  assign acc_err     = req_valid && (req_size != SIZE_WORD);
  assign acc_ok      = req_valid && (req_size == SIZE_WORD) && in_range;
  assign wr_go       = acc_ok && req_write;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int INTR_W = 4,
  parameter int SRC_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [5:0]        idx,
  input  logic [31:0]       wdata,
  input  logic              client_present,
  input  logic              desc_eol,
  input  logic              eol_hit,
  input  logic [INTR_W-1:0] intr_set,
  input  logic              src_we,
  input  logic [SRC_W-1:0]  src_val,
  output logic [31:0]       rdata,
  output logic              irq,
  output logic              load_d_p,
  output logic              load_c_p,
  output logic              start_p,
  output logic              cont_p,
  output logic [2:0]        run_state,
  output logic              eol_flag
);
  import dma_regs_pkg::*;

  logic [31:0] dptr_q, sdesc_q, sbuf_q, grp_q, gdn_q, cmd_q, cfg_q;
  logic [9:0]  scmd_q;
  logic [INTR_W-1:0] mask_q, raw_q, raw_d, masked;
  logic [SRC_W-1:0]  src_q, src_d;
  run_state_e st_q, st_d;
  logic eol_q, eol_d;
  logic wr_cfg, wr_cmd, wr_scmd, wr_ack;
  logic want_ld, want_lc, do_start, do_cont;

  // next-state logic
  always_comb begin
    wr_cfg   = wr_en && (idx == IX_CFG);
    wr_cmd   = wr_en && (idx == IX_CMD);
    wr_scmd  = wr_en && (idx == IX_SCMD);
    wr_ack   = wr_en && (idx == IX_ACK);
    want_ld  = wr_scmd && |(wdata[9:0] & SC_LOADD);
    want_lc  = wr_scmd && wdata[SC_LOADC];
    do_start = want_ld && wdata[SC_BURST] && client_present;
    do_cont  = wr_cmd && cfg_q[0] && !cfg_q[1] && client_present &&
               (st_q == ST_RUN) && desc_eol;
    st_d = st_q;
    if (wr_cfg) begin
      if (wdata[1])  st_d = ST_STOP;
      if (!wdata[0]) st_d = ST_RST;
    end else if (do_start) begin
      st_d = ST_RUN;
    end
    if (do_start)     eol_d = 1'b0;
    else if (eol_hit) eol_d = 1'b1;
    else              eol_d = eol_q;
    raw_d = (raw_q & ~(wr_ack ? wdata[INTR_W-1:0] : '0)) | intr_set;
    src_d = src_we ? src_val : src_q;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dptr_q <= '0; sdesc_q <= '0; sbuf_q <= '0; grp_q <= '0; gdn_q <= '0;
      cmd_q <= '0; cfg_q <= '0; scmd_q <= '0; mask_q <= '0; raw_q <= '0;
      src_q <= SRC_W'(1); st_q <= ST_RST; eol_q <= 1'b0;
      load_d_p <= 1'b0; load_c_p <= 1'b0; start_p <= 1'b0; cont_p <= 1'b0;
    end else begin
      if (wr_en && idx == IX_DPTR)  dptr_q  <= wdata;
      if (wr_en && idx == IX_SDESC) sdesc_q <= wdata;
      if (wr_en && idx == IX_SBUF)  sbuf_q  <= wdata;
      if (wr_en && idx == IX_GRP)   grp_q   <= wdata;
      if (wr_en && idx == IX_GDN)   gdn_q   <= wdata;
      if (wr_en && idx == IX_MASK)  mask_q  <= wdata[INTR_W-1:0];
      if (wr_cmd)  cmd_q  <= wdata;
      if (wr_cfg)  cfg_q  <= wdata;
      if (wr_scmd) scmd_q <= wdata[9:0];
      raw_q    <= raw_d;
      src_q    <= src_d;
      st_q     <= st_d;
      eol_q    <= eol_d;
      load_d_p <= want_ld;
      load_c_p <= want_lc;
      start_p  <= do_start;
      cont_p   <= do_cont;
    end
  end

  assign masked    = raw_q & mask_q;
  assign irq       = |masked;
  assign run_state = st_q;
  assign eol_flag  = eol_q;

  always_comb begin
    unique case (idx)
      IX_DPTR:  rdata = dptr_q;
      IX_SDESC: rdata = sdesc_q;
      IX_SBUF:  rdata = sbuf_q;
      IX_GRP:   rdata = grp_q;
      IX_GDN:   rdata = gdn_q;
      IX_CMD:   rdata = cmd_q;
      IX_CFG:   rdata = cfg_q;
      IX_STAT:  rdata = (32'(src_q) << 8) | (32'(eol_q) << 5) | 32'(st_q);
      IX_MASK:  rdata = 32'(mask_q);
      IX_RAW:   rdata = 32'(raw_q);
      IX_MSKD:  rdata = 32'(masked);
      IX_SCMD:  rdata = 32'(scmd_q);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int NUM_CH = 2,
  parameter int INTR_W = 4,
  parameter int SRC_W  = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = 13 + CH_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [1:0]               req_size,
  input  logic [31:0]              req_wdata,
  output logic                     resp_valid,
  output logic                     resp_err,
  output logic [31:0]              resp_rdata,
  input  logic [NUM_CH-1:0]        client_present,
  input  logic [NUM_CH-1:0]        desc_eol,
  input  logic [NUM_CH-1:0]        eol_hit,
  input  logic [NUM_CH*INTR_W-1:0] intr_set,
  input  logic [NUM_CH-1:0]        src_we,
  input  logic [NUM_CH*SRC_W-1:0]  src_val,
  output logic [NUM_CH-1:0]        irq,
  output logic [NUM_CH-1:0]        load_d_o,
  output logic [NUM_CH-1:0]        load_c_o,
  output logic [NUM_CH-1:0]        start_o,
  output logic [NUM_CH-1:0]        cont_o
);
  logic [1:0] rst_sync;
  logic rst_int_n;
  logic acc_ok, acc_err, wr_go;
  logic [CH_W-1:0] ch_sel;
  logic [5:0] reg_idx;
  logic [31:0] ch_rdata [NUM_CH];
  logic [31:0] rdata_d;
  logic [NUM_CH*3-1:0] run_state_v;
  logic [NUM_CH-1:0] eol_v;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  dma_bus_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .acc_ok(acc_ok), .acc_err(acc_err), .wr_go(wr_go),
    .ch_sel(ch_sel), .reg_idx(reg_idx)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dma_chan_regs #(.INTR_W(INTR_W), .SRC_W(SRC_W)) u_regs (
      .clk(clk), .rst_n(rst_int_n),
      .wr_en(wr_go && (32'(ch_sel) == g)),
      .idx(reg_idx), .wdata(req_wdata),
      .client_present(client_present[g]), .desc_eol(desc_eol[g]),
      .eol_hit(eol_hit[g]), .intr_set(intr_set[g*INTR_W +: INTR_W]),
      .src_we(src_we[g]), .src_val(src_val[g*SRC_W +: SRC_W]),
      .rdata(ch_rdata[g]), .irq(irq[g]),
      .load_d_p(load_d_o[g]), .load_c_p(load_c_o[g]),
      .start_p(start_o[g]), .cont_p(cont_o[g]),
      .run_state(run_state_v[g*3 +: 3]), .eol_flag(eol_v[g])
    );
  end

  assign rdata_d = (acc_ok && !req_write) ? ch_rdata[ch_sel] : 32'd0;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_err   <= acc_err;
      resp_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/dma_regs_chk.sv
module dma_regs_chk #(
  parameter int NUM_CH = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                resp_valid,
  input logic                resp_err,
  input logic [31:0]         resp_rdata,
  input logic [NUM_CH*3-1:0] run_state_v,
  input logic [NUM_CH-1:0]   eol_v,
  input logic [NUM_CH-1:0]   load_d_o,
  input logic [NUM_CH-1:0]   load_c_o,
  input logic [NUM_CH-1:0]   start_o,
  input logic [NUM_CH-1:0]   cont_o
);
  // R3
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  // R3
  err_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> (resp_rdata == 32'd0) && resp_valid);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_c
    // R6
    state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(run_state_v[g*3 +: 3]) == 1);
    // R8
    start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o[g] |-> (run_state_v[g*3 +: 3] == 3'b100) && !eol_v[g]);
    // R9
    cont_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cont_o[g] |-> (run_state_v[g*3 +: 3] == 3'b100));
    // R7
    load_from_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_d_o[g] || load_c_o[g]) |-> resp_valid && !resp_err);
  end
endmodule

bind dma_chan_ctrl dma_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .req_valid(req_valid),
  .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
  .run_state_v(run_state_v), .eol_v(eol_v), .load_d_o(load_d_o),
  .load_c_o(load_c_o), .start_o(start_o), .cont_o(cont_o)
);

// File: tb/tb_dma_chan_ctrl.sv
module tb_dma_chan_ctrl;
  localparam int NCH = 2;
  localparam int IW  = 4;
  localparam int SW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [13:0] req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic resp_valid, resp_err;
  logic [31:0] resp_rdata;
  logic [NCH-1:0] client_present = '1, desc_eol = '0, eol_hit = '0, src_we = '0;
  logic [NCH*IW-1:0] intr_set = '0;
  logic [NCH*SW-1:0] src_val = '0;
  logic [NCH-1:0] irq, load_d_o, load_c_o, start_o, cont_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic r_err;
  logic [31:0] r_data;
  logic [NCH-1:0] p_ld, p_lc, p_st, p_ct;

  always #10 clk = ~clk;

  dma_chan_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .client_present(client_present), .desc_eol(desc_eol), .eol_hit(eol_hit),
    .intr_set(intr_set), .src_we(src_we), .src_val(src_val), .irq(irq),
    .load_d_o(load_d_o), .load_c_o(load_c_o), .start_o(start_o), .cont_o(cont_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one bus access; response and pulses captured at the next falling edge
  task automatic bus(input bit wr, input int ch, input logic [7:0] off,
                     input logic [31:0] d, input logic [1:0] sz);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_wdata = d;
    req_addr = {ch[0], 13'h0} | {6'h0, off};
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk("R3 resp_valid", 32'(resp_valid), 32'd1);
    r_err = resp_err; r_data = resp_rdata;
    p_ld = load_d_o; p_lc = load_c_o; p_st = start_o; p_ct = cont_o;
  endtask

  task automatic wr(input int ch, input logic [7:0] off, input logic [31:0] d);
    bus(1'b1, ch, off, d, 2'd2);
  endtask

  task automatic rd_chk(input string tag, input int ch, input logic [7:0] off,
                        input logic [31:0] exp);
    bus(1'b0, ch, off, 32'd0, 2'd2);
    chk(tag, r_data, exp);
  endtask

  task automatic t_reset;
    rd_chk("R2 status ch0", 0, 8'h88, 32'h101);
    rd_chk("R2 status ch1", 1, 8'h88, 32'h101);
    rd_chk("R2 saved buffer", 0, 8'h5C, 32'h0);
    rd_chk("R2 raw pending", 0, 8'h94, 32'h0);
    chk("R2 irq", 32'(irq), 32'h0);
    chk("R2 pulses", 32'({p_ld, p_lc, p_st, p_ct}), 32'h0);
  endtask

  task automatic t_regs;
    wr(1, 8'h00, 32'hA5A5_0001);
    wr(1, 8'h58, 32'h1000_0040);
    wr(1, 8'h5C, 32'h2000_0080);
    wr(1, 8'h60, 32'h3000_00C0);
    wr(1, 8'h7C, 32'h4000_0100);
    rd_chk("R1 desc ptr", 1, 8'h00, 32'hA5A5_0001);
    rd_chk("R1 saved desc", 1, 8'h58, 32'h1000_0040);
    rd_chk("R1 saved buf", 1, 8'h5C, 32'h2000_0080);
    rd_chk("R1 group", 1, 8'h60, 32'h3000_00C0);
    rd_chk("R1 group down", 1, 8'h7C, 32'h4000_0100);
    rd_chk("R1 other channel untouched", 0, 8'h00, 32'h0);
    wr(1, 8'h40, 32'hDEAD_BEEF);
    rd_chk("R4 unmapped reads zero", 1, 8'h40, 32'h0);
    wr(1, 8'h88, 32'hFFFF_FFFF);
    rd_chk("R4 status read-only", 1, 8'h88, 32'h101);
  endtask

  task automatic t_narrow;
    bus(1'b1, 1, 8'h60, 32'h0, 2'd0);
    chk("R3 narrow write err", 32'(r_err), 32'd1);
    rd_chk("R3 narrow write no change", 1, 8'h60, 32'h3000_00C0);
    bus(1'b0, 1, 8'h60, 32'h0, 2'd1);
    chk("R3 narrow read err", 32'(r_err), 32'd1);
    chk("R3 narrow read zero", r_data, 32'h0);
  endtask

  task automatic t_cfg;
    wr(0, 8'h84, 32'h1);
    rd_chk("R5 enable only keeps RST", 0, 8'h88, 32'h101);
    wr(0, 8'h84, 32'h3);
    rd_chk("R5 stop -> STOPPED", 0, 8'h88, 32'h102);
    rd_chk("R5 cfg readback", 0, 8'h84, 32'h3);
    wr(0, 8'h84, 32'h1);
    rd_chk("R5 enable keeps STOPPED", 0, 8'h88, 32'h102);
    wr(0, 8'h84, 32'h2);
    rd_chk("R5 disable wins over stop", 0, 8'h88, 32'h101);
  endtask

  task automatic t_stream;
    wr(0, 8'h84, 32'h1);
    client_present[0] = 1'b0;
    wr(0, 8'h9C, 32'h160);
    chk("R7 load_d pulse", 32'(p_ld[0]), 32'd1);
    chk("R8 no start without client", 32'(p_st[0]), 32'd0);
    rd_chk("R8 state RST without client", 0, 8'h88, 32'h101);
    client_present[0] = 1'b1;
    wr(0, 8'h9C, 32'h160);
    chk("R8 start pulse", 32'(p_st[0]), 32'd1);
    rd_chk("R8 RUNNING", 0, 8'h88, 32'h104);
    wr(0, 8'h9C, 32'h200);
    chk("R7 context load only", 32'({p_lc[0], p_ld[0], p_st[0]}), 32'b100);
    wr(0, 8'h9C, 32'h040);
    chk("R7 load without burst", 32'({p_lc[0], p_ld[0], p_st[0]}), 32'b010);
    wr(0, 8'h9C, 32'hFFFF_FC20);
    chk("R7 burst alone no pulse", 32'({p_lc[0], p_ld[0], p_st[0]}), 32'b000);
    rd_chk("R7 low 10 bits kept", 0, 8'h9C, 32'h020);
  endtask

  task automatic t_eol_src;
    @(negedge clk); eol_hit[0] = 1'b1;
    @(negedge clk); eol_hit[0] = 1'b0;
    rd_chk("R12 eol flag set", 0, 8'h88, 32'h124);
    @(negedge clk); src_we[0] = 1'b1; src_val[1:0] = 2'b11;
    @(negedge clk); src_we[0] = 1'b0;
    rd_chk("R6 src field", 0, 8'h88, 32'h324);
    wr(0, 8'h9C, 32'h160);
    rd_chk("R8 start clears eol", 0, 8'h88, 32'h304);
  endtask

  task automatic t_cont;
    desc_eol[0] = 1'b1;
    wr(0, 8'h80, 32'h1);
    chk("R9 continue accepted", 32'(p_ct[0]), 32'd1);
    desc_eol[0] = 1'b0;
    wr(0, 8'h80, 32'h1);
    chk("R9 continue needs desc eol", 32'(p_ct[0]), 32'd0);
    desc_eol[0] = 1'b1;
    wr(0, 8'h84, 32'h3);
    wr(0, 8'h80, 32'h1);
    chk("R9 continue ignored when stopped", 32'(p_ct[0]), 32'd0);
    rd_chk("R5 stopped status", 0, 8'h88, 32'h302);
    rd_chk("R1 command readback", 0, 8'h80, 32'h1);
    desc_eol[0] = 1'b0;
  endtask

  task automatic t_irq;
    @(negedge clk); intr_set[3:0] = 4'b0101;
    @(negedge clk); intr_set[3:0] = 4'b0000;
    rd_chk("R10 raw set", 0, 8'h94, 32'h5);
    rd_chk("R11 masked zero", 0, 8'h98, 32'h0);
    chk("R11 irq low", 32'(irq[0]), 32'd0);
    wr(0, 8'h8C, 32'h4);
    chk("R11 irq high after mask", 32'(irq[0]), 32'd1);
    rd_chk("R11 masked value", 0, 8'h98, 32'h4);
    wr(0, 8'h90, 32'h4);
    chk("R11 irq low after ack", 32'(irq[0]), 32'd0);
    rd_chk("R10 ack clears bit", 0, 8'h94, 32'h1);
    rd_chk("R10 ack reads zero", 0, 8'h90, 32'h0);
    wr(0, 8'h8C, 32'hF);
    chk("R11 irq from bit0", 32'(irq[0]), 32'd1);
    @(negedge clk);
    intr_set[3:0] = 4'b0001;
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd2;
    req_addr = 14'h0090; req_wdata = 32'h1;
    @(negedge clk);
    intr_set[3:0] = 4'b0000; req_valid = 1'b0; req_write = 1'b0;
    rd_chk("R10 set beats ack", 0, 8'h94, 32'h1);
    wr(0, 8'h90, 32'h1);
    rd_chk("R10 ack alone clears", 0, 8'h94, 32'h0);
    chk("R11 irq low at end", 32'(irq[0]), 32'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    t_narrow();
    t_cfg();
    t_stream();
    t_eol_src();
    t_cont();
    t_irq();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule